// File: doc/BRIEF.md
# Deep-Sleep Wake Monitor with Glitch Filtering

This block stays powered while the rest of the system is in deep sleep. It watches a bank of general-purpose pins and a few other asynchronous wake sources: two serial-controller activity lines and one external interrupt line. When a sleep-entry strobe arrives, the current synchronized value of every source is stored as a snapshot. From then on, any enabled source whose value moves away from its snapshot raises a wake request. No edge or level is selected; any change of value counts.

Each source class can have a digital filter. A filtered source is sampled only on a slow sampling tick, nominally 10 kHz. It produces a wake only after three consecutive samples all differ from the snapshot. A sample equal to the snapshot restarts the count. Unfiltered sources are compared after a two-flop synchronizer. Pin wakes are honoured only while the global pin-wake select is set. A pin in analog mode reads as a constant 1 and can never cause a wake. The wake request stays high until the sleep sequencer clears it. A sticky cause register records which source class woke the system. It records the class only, not the pin.

Top module: `wake_monitor`

## Requirements
- R1: After reset, `wake_req` is 0 and `wake_cause` is 0.
- R2: After a `sleep_enter` pulse, an enabled pin whose value rises or falls away from its snapshot sets `wake_req` and sets `wake_cause` bit 0, which is the pin class.
- R3: A pin whose bit in `pin_wake_en` is 0 never causes a wake. Enabled pins in the same bank still do.
- R4: While `pin_wake_sel` is 0, pin changes cause no wake. Non-pin sources are not affected by this select.
- R5: A pin with its `pin_analog` bit set reads as 1 and never causes a wake. This holds even when analog mode is switched on during sleep over a pin whose snapshot was 0.
- R6: A source whose bit in `filt_en` is set wakes only after three consecutive `sample_tick` samples all differ from its snapshot. A sample equal to the snapshot restarts the count. Without ticks, the source never wakes. `filt_en` bit 0 is the pin class, and bit 1+k is auxiliary source k.
- R7: Auxiliary sources wake the system through their own cause bits. `aux_in[0]` (serial A) sets cause bit 1, `aux_in[1]` (serial B) sets cause bit 2, and `aux_in[2]` (external interrupt) sets cause bit 3.
- R8: `wake_req` stays 1 until a `wake_clr` pulse. `wake_cause` bits clear only where `cause_clr` has a 1. A 0 in `cause_clr` leaves the bit as it is.
- R9: Source changes while not asleep cause no wake. This covers the time before the first `sleep_enter` and the time after a wake until the next `sleep_enter`.
- R10: Cause bits accumulate across successive wakes until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_enter | input | 1 | One-cycle strobe: capture snapshot and arm |
| sample_tick | input | 1 | One-cycle slow sampling strobe for filtered sources |
| pin_in | input | 24 | Asynchronous pin values |
| pin_wake_en | input | 24 | Per-pin wake enable mask |
| pin_analog | input | 24 | Per-pin analog-mode flag (forces digital value to 1) |
| pin_wake_sel | input | 1 | Global pin-wake select |
| aux_in | input | 3 | Serial A activity, serial B activity, external interrupt |
| filt_en | input | 4 | Filter enable: bit 0 pins, bits 1..3 auxiliary sources |
| wake_clr | input | 1 | One-cycle strobe clearing the wake request |
| cause_clr | input | 4 | Write-one-to-clear strobe for cause bits |
| wake_req | output | 1 | Level-held wake request |
| wake_cause | output | 4 | Sticky wake cause: bit 0 pins, bits 1..3 auxiliary |

## Verification
The assertions assume that `sleep_enter`, `sample_tick` and `wake_clr` are single-cycle strobes. They also assume that the sources have held steady for at least the synchronizer depth before `sleep_enter`, so the snapshot holds settled values. Asynchronous inputs must stay at a new value long enough to cross the synchronizer. The stimulus changes every input at the falling clock edge. It waits four cycles before each sleep entry and holds every source change across several cycles and ticks. No check depends on a signal that is still crossing the synchronizer.

// File: rtl/wake_mon_pkg.sv
package wake_mon_pkg;

   // cause bit positions: the pin class first, then one bit per auxiliary source
   typedef enum int {
      CAUSE_PIN     = 0,
      CAUSE_SER_A   = 1,
      CAUSE_SER_B   = 2,
      CAUSE_EXT_IRQ = 3
   } cause_idx_e;

   function automatic int cnt_width(input int len);
      return (len < 2) ? 1 : $clog2(len + 1);
   endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wake_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
   parameter int WIDTH    = 8,
   parameter int FILT_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [WIDTH-1:0] smp,
   input  logic [WIDTH-1:0] snap,
   output logic [WIDTH-1:0] hit
);
   import wake_mon_pkg::*;
   localparam int CW = cnt_width(FILT_LEN);
   localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN);

   if (FILT_LEN < 1) begin : g_bad_len
      $error("wake_filter: FILT_LEN must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [CW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                run_cnt <= '0;
         else if (clr)              run_cnt <= '0;
         else if (tick) begin
            if (smp[i] == snap[i])  run_cnt <= '0;
            else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
         end
      end

      assign hit[i] = (run_cnt == LIMIT);

      AST_FILT_MATCH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !clr && smp[i] == snap[i]) |=> !hit[i]); // R6
      AST_FILT_HIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hit[i]) |-> $past(tick)); // R6
   end
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor #(
   parameter int NUM_PINS    = 24,
   parameter int NUM_AUX     = 3,
   parameter int FILT_LEN    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_enter,
   input  logic                sample_tick,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] pin_wake_en,
   input  logic [NUM_PINS-1:0] pin_analog,
   input  logic                pin_wake_sel,
   input  logic [NUM_AUX-1:0]  aux_in,
   input  logic [NUM_AUX:0]    filt_en,
   input  logic                wake_clr,
   input  logic [NUM_AUX:0]    cause_clr,
   output logic                wake_req,
   output logic [NUM_AUX:0]    wake_cause
);
   import wake_mon_pkg::*;
   localparam int NUM_SRC   = NUM_PINS + NUM_AUX;
   localparam int NUM_CAUSE = NUM_AUX + 1;

   if (NUM_PINS < 1 || NUM_AUX < 1) begin : g_bad_size
      $error("wake_monitor: need at least one pin and one auxiliary source");
   end

   logic [NUM_SRC-1:0]   raw_src, src_s, snap_q, filt_hit, diff_raw;
   logic [NUM_PINS-1:0]  pin_mask, pin_pick;
   logic [NUM_CAUSE-1:0] ev;
   logic                 asleep, fire;

   // analog-mode pins read as constant 1 on the digital path
   assign raw_src = {aux_in, pin_in | pin_analog};

   wake_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_src), .q(src_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           snap_q <= '0;
      else if (sleep_enter) snap_q <= src_s;
   end

   wake_filter #(.WIDTH(NUM_SRC), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .clr(sleep_enter), .tick(sample_tick),
      .smp(src_s), .snap(snap_q), .hit(filt_hit)
   );

   assign diff_raw = src_s ^ snap_q;
   assign pin_mask = pin_wake_en & ~pin_analog;
   assign pin_pick = filt_en[CAUSE_PIN] ? filt_hit[NUM_PINS-1:0] : diff_raw[NUM_PINS-1:0];
   assign ev[CAUSE_PIN] = pin_wake_sel & (|(pin_pick & pin_mask));

   for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
      assign ev[k+1] = filt_en[k+1] ? filt_hit[NUM_PINS+k] : diff_raw[NUM_PINS+k];
   end

   assign fire = asleep & ~sleep_enter & (|ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep     <= 1'b0;
         wake_req   <= 1'b0;
         wake_cause <= '0;
      end else begin
         if (sleep_enter) asleep <= 1'b1;
         else if (fire)   asleep <= 1'b0;

         if (fire)          wake_req <= 1'b1;
         else if (wake_clr) wake_req <= 1'b0;

         wake_cause <= (wake_cause & ~cause_clr) | (fire ? ev : '0);
      end
   end

   AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> $past(asleep)); // R9
   AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && !wake_clr) |=> wake_req); // R8
   AST_CAUSE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> (wake_cause != '0)); // R2
   AST_PIN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_cause[CAUSE_PIN]) |-> $past(pin_wake_sel)); // R4
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_cause[CAUSE_PIN] && !cause_clr[CAUSE_PIN]) |=> wake_cause[CAUSE_PIN]); // R8
endmodule

// File: tb/tb_wake_monitor.sv
module tb_wake_monitor;
   localparam int NP = 24;
   localparam int NA = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_enter = 1'b0, sample_tick = 1'b0, pin_wake_sel = 1'b0, wake_clr = 1'b0;
   logic [NP-1:0] pin_in = '0, pin_wake_en = '0, pin_analog = '0;
   logic [NA-1:0] aux_in = '0;
   logic [NA:0]   filt_en = '0, cause_clr = '0;
   logic          wake_req;
   logic [NA:0]   wake_cause;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic        wake;
      logic [NA:0] cause;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   wake_monitor dut (
      .clk(clk), .rst_n(rst_n), .sleep_enter(sleep_enter), .sample_tick(sample_tick),
      .pin_in(pin_in), .pin_wake_en(pin_wake_en), .pin_analog(pin_analog),
      .pin_wake_sel(pin_wake_sel), .aux_in(aux_in), .filt_en(filt_en),
      .wake_clr(wake_clr), .cause_clr(cause_clr),
      .wake_req(wake_req), .wake_cause(wake_cause)
   );

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         exp_t e;
         wait (sb_q.size() != 0);
         e = sb_q.pop_front();
         checks++;
         if (wake_req !== e.wake || wake_cause !== e.cause) begin
            errors++;
            $display("FAIL %s: wake_req=%0b wake_cause=%b expected wake_req=%0b wake_cause=%b",
                     e.tag, wake_req, wake_cause, e.wake, e.cause);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input logic w, input logic [NA:0] c, input string tag);
      exp_t e;
      e.wake = w; e.cause = c; e.tag = tag;
      sb_q.push_back(e);
      #1;
   endtask

   task automatic go_sleep();
      cyc(4);
      sleep_enter = 1'b1; cyc(1); sleep_enter = 1'b0;
   endtask

   task automatic tick();
      sample_tick = 1'b1; cyc(1); sample_tick = 1'b0; cyc(2);
   endtask

   task automatic clear_all();
      wake_clr = 1'b1; cause_clr = '1; cyc(1);
      wake_clr = 1'b0; cause_clr = '0; cyc(2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(3); rst_n = 1'b1; cyc(2);
      expect_out(1'b0, 4'b0000, "R1 reset state");

      // R9: change before any sleep entry
      pin_wake_en = '1; pin_wake_sel = 1'b1;
      pin_in[1] = 1'b1; cyc(6);
      expect_out(1'b0, 4'b0000, "R9 no wake before sleep");
      pin_in = '0;

      // R2: rising change
      go_sleep(); cyc(5);
      expect_out(1'b0, 4'b0000, "R2 idle while asleep");
      pin_in[5] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b0001, "R2 rising pin wake");

      // R8: hold, no-op clear, wake clear, cause W1C
      cyc(10);
      expect_out(1'b1, 4'b0001, "R8 wake held");
      cause_clr = 4'b1110; cyc(1); cause_clr = '0; cyc(1);
      expect_out(1'b1, 4'b0001, "R8 zero bits in cause_clr no effect");
      wake_clr = 1'b1; cyc(1); wake_clr = 1'b0; cyc(1);
      expect_out(1'b0, 4'b0001, "R8 wake cleared cause kept");
      cause_clr = 4'b0001; cyc(1); cause_clr = '0; cyc(1);
      expect_out(1'b0, 4'b0000, "R8 cause W1C");

      // R9: after wake, not asleep
      pin_in[5] = 1'b0; cyc(6);
      expect_out(1'b0, 4'b0000, "R9 no wake after wake");

      // R2: falling change
      pin_in = '1; go_sleep();
      pin_in[23] = 1'b0; cyc(5);
      expect_out(1'b1, 4'b0001, "R2 falling pin wake");
      clear_all();

      // R3: masked pin
      pin_in = '0; pin_wake_en = ~(24'd1 << 7); go_sleep();
      pin_in[7] = 1'b1; cyc(8);
      expect_out(1'b0, 4'b0000, "R3 masked pin ignored");
      pin_in[8] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b0001, "R3 enabled pin still wakes");
      clear_all();

      // R4: global select off; R7 aux unaffected
      pin_in = '0; pin_wake_en = '1; pin_wake_sel = 1'b0; go_sleep();
      pin_in = 24'h00F000; cyc(8);
      expect_out(1'b0, 4'b0000, "R4 pin wake blocked by select");
      aux_in[2] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b1000, "R7 ext irq wakes with select off");
      clear_all();
      aux_in = '0; pin_wake_sel = 1'b1; pin_in = '0;

      // R5: analog pins
      pin_analog[3] = 1'b1; go_sleep();
      pin_in[3] = 1'b1; cyc(6);
      expect_out(1'b0, 4'b0000, "R5 analog pin change ignored");
      pin_analog[9] = 1'b1; cyc(6);
      expect_out(1'b0, 4'b0000, "R5 analog enabled during sleep ignored");
      pin_in[4] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b0001, "R5 digital pin still wakes");
      clear_all();
      pin_analog = '0; pin_in = '0;

      // R6: filtered pins
      filt_en = 4'b0001; go_sleep();
      pin_in[2] = 1'b1; cyc(5);
      expect_out(1'b0, 4'b0000, "R6 no ticks no wake");
      tick(); tick();
      expect_out(1'b0, 4'b0000, "R6 two samples not enough");
      pin_in[2] = 1'b0; cyc(4); tick();
      pin_in[2] = 1'b1; cyc(4); tick(); tick();
      expect_out(1'b0, 4'b0000, "R6 matching sample restarts count");
      tick(); cyc(1);
      expect_out(1'b1, 4'b0001, "R6 third differing sample wakes");
      clear_all();
      filt_en = '0; pin_in = '0;

      // R7 / R10: serial sources, accumulation
      go_sleep();
      aux_in[0] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b0010, "R7 serial A wake");
      wake_clr = 1'b1; cyc(1); wake_clr = 1'b0;
      go_sleep();
      aux_in[1] = 1'b1; cyc(5);
      expect_out(1'b1, 4'b0110, "R10 causes accumulate, R7 serial B");
      wake_clr = 1'b1; cause_clr = 4'b0100; cyc(1);
      wake_clr = 1'b0; cause_clr = '0; cyc(1);
      expect_out(1'b0, 4'b0010, "R8 selective cause clear");
      clear_all();
      expect_out(1'b0, 4'b0000, "R8 full cause clear");

      // R6: filtered auxiliary source
      aux_in = '0; filt_en = 4'b1000; go_sleep();
      aux_in[2] = 1'b1; cyc(5);
      expect_out(1'b0, 4'b0000, "R6 filtered aux waits for ticks");
      tick(); tick(); tick(); cyc(1);
      expect_out(1'b1, 4'b1000, "R6 filtered aux wakes after three");

      cyc(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule